// File: doc/BRIEF.md
# SPI Read Splicer with Measurement Status Byte

This block sits on the SPI link between a microcontroller (the master) and an ADC that returns 24-bit conversions. Serial clock and chip-select from the master go straight through to the ADC, and the ADC's data-ready line goes straight back to the master. Each time the ADC announces a new conversion, the block takes a snapshot of eight bits of local status:

- five context input bits;
- the current two-bit measurement range;
- a flag that records whether the range has moved since the last snapshot.

The master then performs one 32-bit read. During the first 24 bit periods its MISO line carries the ADC's own data. During the last 8 bit periods the block substitutes the snapshot, most significant bit first. The master therefore receives the conversion and the conditions it was taken under as one word.

The bus uses SPI mode 0: the clock idles low, data changes after a falling edge, and the master samples on a rising edge. All slow inputs are brought into the system clock domain by synchronizer chains before use. Chip-select is counted from its assertion, and the bit position restarts whenever chip-select is released.

Top module: `spi_status_splicer`

## Requirements
- R1: `adc_sclk` and `adc_cs_n` always equal `m_sclk` and `m_cs_n`, and `m_drdy` always equals `adc_drdy`.
- R2: In a read, bit periods 0 to 23 (the first 24 bits the master samples) carry `adc_miso` on `m_miso`.
- R3: Bit periods 24 to 31 carry the status byte, most significant bit first. In the received 32-bit word, bits [7:3] hold the context, bit [2] holds the range-changed flag and bits [1:0] hold the range. After the 32nd falling edge, `m_miso` reads 0 until chip-select is released.
- R4: A rising edge on `adc_drdy` while chip-select is inactive captures the status byte from the current context and range inputs.
- R5: The captured flag is 1 exactly when the range input changed at any time since the previous capture. This includes a change that later returns to the old value. Each capture clears the flag.
- R6: A rising edge on `adc_drdy` while chip-select is active does not alter the byte being read. The capture is performed once chip-select is released.
- R7: Releasing chip-select part way through a read resets the bit position, so the next read starts again at bit 0.
- R8: After reset, and before any capture, the status byte is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| m_sclk | input | 1 | Serial clock from the master |
| m_cs_n | input | 1 | Chip-select from the master, active low |
| m_miso | output | 1 | Serial data to the master |
| m_drdy | output | 1 | Data-ready forwarded to the master |
| adc_sclk | output | 1 | Serial clock to the ADC |
| adc_cs_n | output | 1 | Chip-select to the ADC |
| adc_miso | input | 1 | Serial data from the ADC |
| adc_drdy | input | 1 | Data-ready from the ADC, active high |
| ctx_in | input | CTX_W (5) | Context bits to record |
| rng_in | input | RNG_W (2) | Current measurement range |

## Verification
The assertions rely on several properties of the inputs:

- Every serial-clock phase lasts well beyond the synchronizer latency, so no edge is lost or merged.
- The serial clock is low whenever chip-select changes.
- The range and context inputs stay steady for several system clocks after each change.

The bench keeps within these limits. Each serial-clock phase lasts 40 ns against a 5 ns system clock. Chip-select moves only while the clock is low. Every input change is followed by a wait of at least ten system clocks before the next event.

// File: rtl/spl_pkg.sv
// Package: shared widths and the layout of the status byte.
// Assumes: the range field sits in the low bits, where the receiver decodes it.
package spl_pkg;
    parameter int unsigned CTX_W = 5;
    parameter int unsigned RNG_W = 2;
    localparam int unsigned STAT_W = CTX_W + 1 + RNG_W;

    typedef struct packed {
        logic [CTX_W-1:0] ctx;
        logic             chg;
        logic [RNG_W-1:0] rng;
    } stat_t;
endpackage

// File: rtl/spl_sync.sv
// Module: spl_sync
// Carries a vector of asynchronous inputs through a chain of flops
// into the clk domain.
// Assumes: each bit is meaningful alone; there is no bus coherency across bits.
module spl_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the sampled value one stage along every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spl_bitcnt.sv
// Module: spl_bitcnt
// Counts falling serial-clock edges while chip-select is active and
// reports when the status byte is due, and which bit of it.
// Assumes: mode 0 (clock idles low) and clock phases longer than a few clk
// cycles; the count saturates at the full word length.
module spl_bitcnt #(
    parameter int unsigned ADC_BITS = 24,
    parameter int unsigned STAT_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sclk_s,
    input  logic                      cs_act_s,
    output logic                      in_stat,
    output logic                      past_word,
    output logic [$clog2(STAT_W)-1:0] stat_idx
);
    localparam int unsigned WORD = ADC_BITS + STAT_W;
    localparam int unsigned CW   = $clog2(WORD + 1);
    localparam int unsigned IW   = $clog2(STAT_W);

    logic          sclk_q;
    logic [CW-1:0] cnt_q;
    logic          fall;
    logic [CW-1:0] off;

    assign fall = sclk_q & ~sclk_s;

    // Remember the previous clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    // Bit position: cleared when idle, advanced per falling edge up to WORD.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act_s)                 cnt_q <= '0;
        else if (fall && cnt_q != CW'(WORD))     cnt_q <= cnt_q + CW'(1);
    end

    // Decode the window and the status bit index.
    always_comb begin
        off       = cnt_q - CW'(ADC_BITS);
        in_stat   = cs_act_s && (cnt_q >= CW'(ADC_BITS)) && (cnt_q < CW'(WORD));
        past_word = cs_act_s && (cnt_q >= CW'(WORD));
        stat_idx  = IW'(STAT_W - 1) - off[IW-1:0];
    end

    // R7: the position only steps by one or returns to zero.
    p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CW'(1) || cnt_q == '0));

    // R7: once chip-select is released, the next position is zero.
    p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act_s |=> (cnt_q == '0));

    // R3: the count never passes the word length.
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(WORD));
endmodule

// File: rtl/spl_tag.sv
// Module: spl_tag
// Holds the status byte. It records range changes, captures on data-ready
// and defers any capture that arrives while a read is in progress.
// Assumes: inputs are already synchronized into the clk domain.
module spl_tag
    import spl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drdy_s,
    input  logic             cs_act_s,
    input  logic [CTX_W-1:0] ctx_s,
    input  logic [RNG_W-1:0] rng_s,
    output stat_t            tag
);
    logic             drdy_q;
    logic [RNG_W-1:0] rng_q;
    logic             flag_q;
    logic             pend_q;
    logic             rise;
    logic             chg_now;
    logic             cap;

    assign rise    = drdy_s & ~drdy_q;
    assign chg_now = (rng_s != rng_q);
    assign cap     = !cs_act_s && (rise || pend_q);

    // Delay data-ready and range by one clock for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drdy_q <= 1'b0;
            rng_q  <= '0;
        end else begin
            drdy_q <= drdy_s;
            rng_q  <= rng_s;
        end
    end

    // Sticky range-changed flag, cleared by each capture.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (cap)     flag_q <= 1'b0;
        else if (chg_now) flag_q <= 1'b1;
    end

    // Remember a data-ready that arrived while a read was active.
    always_ff @(posedge clk) begin
        if (!rst_n)    pend_q <= 1'b0;
        else if (cap)  pend_q <= 1'b0;
        else if (rise) pend_q <= 1'b1;
    end

    // Load the snapshot, including a change seen in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag <= '0;
        end else if (cap) begin
            tag.ctx <= ctx_s;
            tag.chg <= flag_q | chg_now;
            tag.rng <= rng_s;
        end
    end

    // R6: the byte is frozen while chip-select stays active.
    p_tag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act_s && $past(cs_act_s)) |-> $stable(tag));

    // R6: a deferred capture is served as soon as chip-select is released.
    p_pend_served_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !cs_act_s) |=> !pend_q);

    // R5: a range change that is not captured is remembered.
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_now && !cap) |=> flag_q);

    // R4: a capture records the range that was present.
    p_cap_rng_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (tag.rng == $past(rng_s)));
endmodule

// File: rtl/spi_status_splicer.sv
// Module: spi_status_splicer (top)
// Forwards the SPI clock and select to the ADC and data-ready to the master.
// On MISO it passes the ADC's 24 bits, then inserts the status byte.
// Assumes: SPI mode 0, with serial clock phases much longer than the clk period.
module spi_status_splicer
    import spl_pkg::*;
#(
    parameter int unsigned ADC_BITS    = 24,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m_sclk,
    input  logic             m_cs_n,
    output logic             m_miso,
    output logic             m_drdy,
    output logic             adc_sclk,
    output logic             adc_cs_n,
    input  logic             adc_miso,
    input  logic             adc_drdy,
    input  logic [CTX_W-1:0] ctx_in,
    input  logic [RNG_W-1:0] rng_in
);
    localparam int unsigned SW = CTX_W + RNG_W + 3;
    localparam int unsigned IW = $clog2(STAT_W);

    logic [SW-1:0]    raw;
    logic [SW-1:0]    syn;
    logic [CTX_W-1:0] ctx_s;
    logic [RNG_W-1:0] rng_s;
    logic             drdy_s;
    logic             sclk_s;
    logic             cs_act_s;
    logic             in_stat;
    logic             past_word;
    logic [IW-1:0]    stat_idx;
    stat_t            tag;
    logic [STAT_W-1:0] tag_bits;

    // Straight wires between the master and the ADC.
    assign adc_sclk = m_sclk;
    assign adc_cs_n = m_cs_n;
    assign m_drdy   = adc_drdy;

    assign raw = {ctx_in, rng_in, adc_drdy, m_sclk, ~m_cs_n};
    assign {ctx_s, rng_s, drdy_s, sclk_s, cs_act_s} = syn;

    spl_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    spl_bitcnt #(.ADC_BITS(ADC_BITS), .STAT_W(STAT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_act_s(cs_act_s),
        .in_stat(in_stat), .past_word(past_word), .stat_idx(stat_idx)
    );

    spl_tag u_tag (
        .clk(clk), .rst_n(rst_n), .drdy_s(drdy_s), .cs_act_s(cs_act_s),
        .ctx_s(ctx_s), .rng_s(rng_s), .tag(tag)
    );

    assign tag_bits = tag;

    // MISO source: the status bit in its window, zero after the word, else the ADC.
    always_comb begin
        if (in_stat)        m_miso = tag_bits[stat_idx];
        else if (past_word) m_miso = 1'b0;
        else                m_miso = adc_miso;
    end

    // R3: the status window and the post-word region never overlap.
    p_window_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_stat && past_word));

    // R3: the status window is always followed by the window or the post-word region.
    p_window_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_stat) && cs_act_s) |-> (in_stat || past_word));
endmodule

// File: tb/spi_status_splicer_bench.sv
`timescale 1ns/100ps
// Scoreboard bench: the read driver pushes expected words into a queue,
// and a monitor pops one and compares it with every completed read.
module spi_status_splicer_bench;
    localparam int HALF = 40;

    typedef struct {
        logic [31:0] w;
        string       lbl;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_sclk = 1'b0;
    logic       m_cs_n = 1'b1;
    logic       m_miso;
    logic       m_drdy;
    logic       adc_sclk;
    logic       adc_cs_n;
    logic       adc_miso = 1'b0;
    logic       adc_drdy = 1'b0;
    logic [4:0] ctx_in = '0;
    logic [1:0] rng_in = '0;

    int checks = 0;
    int errors = 0;

    exp_t        sb[$];
    logic [31:0] rx_word;
    event        rx_ev;

    // Bench model of the status byte.
    logic [4:0] cur_ctx = '0;
    logic [1:0] cur_rng = '0;
    logic       chg_seen = 1'b0;
    logic [7:0] exp_tag = '0;

    always #2.5 clk = ~clk;

    spi_status_splicer u_spi_status_splicer (
        .clk(clk), .rst_n(rst_n), .m_sclk(m_sclk), .m_cs_n(m_cs_n),
        .m_miso(m_miso), .m_drdy(m_drdy), .adc_sclk(adc_sclk),
        .adc_cs_n(adc_cs_n), .adc_miso(adc_miso), .adc_drdy(adc_drdy),
        .ctx_in(ctx_in), .rng_in(rng_in)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_inputs(input logic [4:0] c, input logic [1:0] r);
        if (r != cur_rng) chg_seen = 1'b1;
        cur_ctx = c;
        cur_rng = r;
        ctx_in  = c;
        rng_in  = r;
        #50;
    endtask

    task automatic pulse_drdy();
        adc_drdy = 1'b1;
        #10;
        check(m_drdy === 1'b1, "R1 drdy high", 32'(m_drdy), 32'd1);
        #40;
        adc_drdy = 1'b0;
        #10;
        check(m_drdy === 1'b0, "R1 drdy low", 32'(m_drdy), 32'd0);
        #90;
        exp_tag  = {cur_ctx, chg_seen, cur_rng};
        chg_seen = 1'b0;
    endtask

    // Master plus ADC model. Runs nbits bit periods.
    task automatic spi_xfer(input logic [23:0] adc_val, input int nbits,
                            output logic [31:0] got);
        got = '0;
        m_cs_n = 1'b0;
        #5;
        check(adc_cs_n === 1'b0, "R1 cs forward", 32'(adc_cs_n), 32'd0);
        for (int i = 0; i < nbits; i++) begin
            adc_miso = (i < 24) ? adc_val[23-i] : 1'b0;
            #(HALF);
            got[31-i] = m_miso;
            m_sclk = 1'b1;
            if (i == 0) begin
                #5;
                check(adc_sclk === 1'b1, "R1 sclk forward", 32'(adc_sclk), 32'd1);
                #(HALF - 5);
            end else begin
                #(HALF);
            end
            m_sclk = 1'b0;
        end
    endtask

    task automatic read_word(input logic [23:0] adc_val, input string lbl);
        exp_t        e;
        logic [31:0] got;
        e.w   = {adc_val, exp_tag};
        e.lbl = lbl;
        sb.push_back(e);
        spi_xfer(adc_val, 32, got);
        adc_miso = 1'b1;
        #(HALF);
        check(m_miso === 1'b0, "R3 zero after word", 32'(m_miso), 32'd0);
        m_cs_n = 1'b1;
        #100;
        rx_word = got;
        ->rx_ev;
        #10;
    endtask

    // Monitor: compare each received word with the oldest expectation.
    always @(rx_ev) begin
        if (sb.size() == 0) begin
            check(1'b0, "scoreboard empty", rx_word, 32'd0);
        end else begin
            exp_t e;
            e = sb.pop_front();
            check(rx_word[31:8] === e.w[31:8], {"R2 adc bits ", e.lbl},
                  rx_word, e.w);
            check(rx_word[7:0] === e.w[7:0], {"R3 status byte ", e.lbl},
                  rx_word, e.w);
        end
    end

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] junk;
        #50;
        rst_n = 1'b1;
        #50;

        // R1: idle forwarding of MISO and data-ready.
        adc_miso = 1'b1;
        #10;
        check(m_miso === 1'b1, "R1 idle miso", 32'(m_miso), 32'd1);
        adc_miso = 1'b0;
        #10;
        check(m_miso === 1'b0, "R1 idle miso", 32'(m_miso), 32'd0);

        // R8: read before any capture returns a zero status byte.
        set_inputs(5'h15, 2'd0);
        read_word(24'hA5C3F0, "R8 reset byte");

        // R4 and R5: the first range change is flagged.
        set_inputs(5'h0B, 2'd1);
        pulse_drdy();
        read_word(24'h123456, "R4 R5 first change");

        // R5: the same range again gives a clear flag.
        set_inputs(5'h1E, 2'd1);
        pulse_drdy();
        read_word(24'hFFFFFF, "R5 no change");

        // R5: a change and a return to the old range still set the flag.
        set_inputs(5'h01, 2'd2);
        set_inputs(5'h01, 2'd1);
        pulse_drdy();
        read_word(24'h000001, "R5 round trip");

        // R3: range 3 with all context bits set.
        set_inputs(5'h1F, 2'd3);
        pulse_drdy();
        read_word(24'h800000, "R3 all ones ctx");

        // R6: data-ready during a read is deferred.
        set_inputs(5'h0A, 2'd0);
        fork
            read_word(24'h5A5A5A, "R6 held byte");
            begin
                #800;
                pulse_drdy();
            end
        join
        read_word(24'h0F0F0F, "R6 deferred capture");

        // R7: an aborted read restarts from bit 0.
        spi_xfer(24'hDEAD00, 10, junk);
        m_cs_n = 1'b1;
        #100;
        read_word(24'hC0FFEE, "R7 after abort");

        #100;
        check(sb.size() == 0, "scoreboard drained", 32'(sb.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule